// File: doc/BRIEF.md
# Challenge-Response Authentication Register Controller

This block is the register front end of a battery-side authentication slave. A host writes a secret-select register, a 32-bit challenge register and a status register over a simple synchronous register port. The block keeps a small one-time-programmable secret store as a register array. When the select register is written, the block fetches two secrets from that store: one defines the hash function and the other seeds it. It then holds the pair, with the accepted challenge, on its outputs toward an external hash engine. After a configurable number of cycles that stands in for one bit time, it latches the engine's 8-bit answer into a readable authentication register.

The engine's seed is used up by every calculation, so the block only arms after a fresh select write. A challenge that arrives without one is refused: no calculation starts, and a sticky bus-error flag is raised. A lock word at store index 0 can only gain bits. Each set bit hides one secret slot from the host for good, while the engine can still fetch that slot internally.

Top module: `auth_regs`

Register map with the default parameters (`addr`): 0 status, 1 select, 2 challenge, 3 result, 8 lock word, 9..12 secret slots 0..3. All other addresses read as zero and ignore writes.

## Requirements
- R1: After reset, status, select, result and lock word all read 0 and `hash_go` is low.
- R2: A write to select (bits [1:0] pick the function slot, bits [3:2] the seed slot, and both may name the same slot) takes effect at the next edge. At that edge it loads `hash_func` and `hash_seed` from those slots and sets status bit 2 (ready).
- R3: A challenge write while ready and idle is accepted at its edge. At that edge `hash_chal` takes the value, `hash_go` pulses for one cycle and ready clears. Status bit 0 (busy) is then high for BIT_CYCLES cycles. At the BIT_CYCLES-th edge after acceptance, the result register takes `hash_result`.
- R4: A challenge write while idle and not ready starts nothing. It sets status bit 1 (bus error) and leaves the result unchanged.
- R5: A challenge write while busy is ignored, including in the last busy cycle. It raises no error and changes neither `hash_chal` nor the result.
- R6: A select write while busy is ignored. The secrets on the outputs, the select readback and ready stay unchanged.
- R7: The bus-error bit stays set until the host writes status with bit 1 = 1. Writes with bit 1 = 0 leave it set.
- R8: A write to the lock word ORs its low bits into the stored lock bits (bit k locks slot k). Lock bits are never cleared, and the lock word reads back.
- R9: Host reads of a locked slot return 0. Host writes to a locked slot are dropped and set the bus-error bit. Unlocked slots read and write normally.
- R10: A select write still loads locked slots into `hash_func` and `hash_seed`.
- R11: Read data is registered and appears in the cycle after `rd_en`. A result read in the same cycle the result register is written returns the previous result. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host register address |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Registered host read data |
| hash_go | output | 1 | One-cycle start pulse to the hash engine |
| hash_func | output | 32 | Function-defining secret |
| hash_seed | output | 32 | Seed secret |
| hash_chal | output | 32 | Accepted challenge |
| hash_result | input | 8 | Hash engine answer |

## Verification
Two pairs of events can share a clock edge. The first pair is the end of a calculation and a host read of the result register. The bench issues the read so that its edge is exactly the BIT_CYCLES-th edge after acceptance, and expects the previous result, then the new one on the next read. The second pair is the end of a calculation and a new challenge write. The bench places that write on the final busy edge and expects neither an error nor a change of the held challenge. Random select/challenge rounds, with some rounds deliberately skipping the select, are judged against a bench model of the engine and of the error flag.

// File: rtl/auth_pkg.sv
package auth_pkg;
  // register indices below the secret-store window
  localparam int REG_STATUS = 0;
  localparam int REG_SELECT = 1;
  localparam int REG_CHAL   = 2;
  localparam int REG_AUTH   = 3;
  // status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_BERR  = 1;
  localparam int ST_READY = 2;
endpackage

// File: rtl/auth_otp.sv
// Secret store: index 0 is the set-only lock word, index k+1 is slot k.
module auth_otp #(
  parameter int DATA_W      = 32,
  parameter int NUM_SECRETS = 4,
  parameter int IDX_W       = 3,
  parameter int SEL_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_blocked,
  input  logic [SEL_W-1:0]  eng_fsel,
  input  logic [SEL_W-1:0]  eng_ssel,
  output logic [DATA_W-1:0] eng_fdata,
  output logic [DATA_W-1:0] eng_sdata,
  output logic [NUM_SECRETS-1:0] lock_bits
);
  logic [DATA_W-1:0] mem [NUM_SECRETS];
  logic [NUM_SECRETS-1:0] hit;
  logic lock_hit;

  assign lock_hit = (host_idx == '0);

  genvar k;
  generate
    for (k = 0; k < NUM_SECRETS; k++) begin : g_slot
      assign hit[k] = (host_idx == IDX_W'(k + 1));
      always_ff @(posedge clk) begin
        if (host_wr && hit[k] && !lock_bits[k]) mem[k] <= host_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lock_bits <= '0;
    else if (host_wr && lock_hit) lock_bits <= lock_bits | host_wdata[NUM_SECRETS-1:0];
  end

  always_comb begin
    host_rdata = lock_hit ? DATA_W'(lock_bits) : '0;
    for (int i = 0; i < NUM_SECRETS; i++) begin
      if (hit[i] && !lock_bits[i]) host_rdata = mem[i];
    end
  end

  assign host_blocked = host_wr && |(hit & lock_bits);
  assign eng_fdata    = mem[eng_fsel];
  assign eng_sdata    = mem[eng_ssel];
endmodule

// File: rtl/auth_seq.sv
// Arming, busy window and result capture.
module auth_seq #(
  parameter int DATA_W     = 32,
  parameter int RES_W      = 8,
  parameter int BIT_CYCLES = 16,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic [DATA_W-1:0] fsecret,
  input  logic [DATA_W-1:0] ssecret,
  input  logic              chal_wr,
  input  logic [DATA_W-1:0] chal_data,
  input  logic [RES_W-1:0]  hash_result,
  output logic              busy,
  output logic              armed,
  output logic              chal_refused,
  output logic              sel_taken,
  output logic              hash_go,
  output logic [DATA_W-1:0] func_q,
  output logic [DATA_W-1:0] seed_q,
  output logic [DATA_W-1:0] chal_q,
  output logic [RES_W-1:0]  auth_q
);
  logic [CNT_W-1:0] cnt;

  assign chal_refused = chal_wr && !busy && !armed;
  assign sel_taken    = sel_wr && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      armed   <= 1'b0;
      hash_go <= 1'b0;
      cnt     <= '0;
      func_q  <= '0;
      seed_q  <= '0;
      chal_q  <= '0;
      auth_q  <= '0;
    end else begin
      hash_go <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy   <= 1'b0;
          auth_q <= hash_result;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (chal_wr && armed) begin
        busy    <= 1'b1;
        armed   <= 1'b0;
        hash_go <= 1'b1;
        cnt     <= CNT_W'(BIT_CYCLES - 1);
        chal_q  <= chal_data;
      end else if (sel_wr) begin
        func_q <= fsecret;
        seed_q <= ssecret;
        armed  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/auth_regs.sv
module auth_regs #(
  parameter int ADDR_W      = 4,
  parameter int RES_W       = 8,
  parameter int NUM_SECRETS = 4,
  parameter int BIT_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              hash_go,
  output logic [31:0]       hash_func,
  output logic [31:0]       hash_seed,
  output logic [31:0]       hash_chal,
  input  logic [RES_W-1:0]  hash_result
);
  import auth_pkg::*;

  localparam int DATA_W = 32;
  localparam int SEL_W  = (NUM_SECRETS > 1) ? $clog2(NUM_SECRETS) : 1;
  localparam int IDX_W  = ADDR_W - 1;
  localparam int CNT_W  = $clog2(BIT_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_SELECT = ADDR_W'(REG_SELECT);
  localparam logic [ADDR_W-1:0] A_CHAL   = ADDR_W'(REG_CHAL);
  localparam logic [ADDR_W-1:0] A_AUTH   = ADDR_W'(REG_AUTH);

  logic [IDX_W-1:0]    otp_idx;
  logic                in_otp, sel_wr, chal_wr, sel_taken;
  logic [DATA_W-1:0]   otp_rdata, fsecret, ssecret;
  logic                otp_blocked, chal_refused, busy, armed, berr;
  logic [2*SEL_W-1:0]  sel_q;
  logic [RES_W-1:0]    auth_q;
  logic [NUM_SECRETS-1:0] lock_bits;

  assign otp_idx = addr[IDX_W-1:0];
  assign in_otp  = addr[ADDR_W-1] && (otp_idx <= IDX_W'(NUM_SECRETS));
  assign sel_wr  = wr_en && (addr == A_SELECT);
  assign chal_wr = wr_en && (addr == A_CHAL);

  auth_otp #(.DATA_W(DATA_W), .NUM_SECRETS(NUM_SECRETS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_otp (
    .clk(clk), .rst(rst),
    .host_wr(wr_en && in_otp), .host_idx(otp_idx), .host_wdata(wdata),
    .host_rdata(otp_rdata), .host_blocked(otp_blocked),
    .eng_fsel(wdata[SEL_W-1:0]), .eng_ssel(wdata[2*SEL_W-1:SEL_W]),
    .eng_fdata(fsecret), .eng_sdata(ssecret), .lock_bits(lock_bits)
  );

  auth_seq #(.DATA_W(DATA_W), .RES_W(RES_W), .BIT_CYCLES(BIT_CYCLES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst),
    .sel_wr(sel_wr), .fsecret(fsecret), .ssecret(ssecret),
    .chal_wr(chal_wr), .chal_data(wdata), .hash_result(hash_result),
    .busy(busy), .armed(armed), .chal_refused(chal_refused), .sel_taken(sel_taken),
    .hash_go(hash_go), .func_q(hash_func), .seed_q(hash_seed),
    .chal_q(hash_chal), .auth_q(auth_q)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (sel_taken) sel_q <= wdata[2*SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) berr <= 1'b0;
    else if (chal_refused || otp_blocked) berr <= 1'b1;
    else if (wr_en && (addr == A_STATUS) && wdata[ST_BERR]) berr <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      if (in_otp) rdata <= otp_rdata;
      else begin
        case (addr)
          A_STATUS: rdata <= DATA_W'({armed, berr, busy});
          A_SELECT: rdata <= DATA_W'(sel_q);
          A_CHAL:   rdata <= hash_chal;
          A_AUTH:   rdata <= DATA_W'(auth_q);
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/auth_regs_chk.sv
module auth_regs_chk #(
  parameter int ADDR_W      = 4,
  parameter int RES_W       = 8,
  parameter int NUM_SECRETS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              clr_bit,
  input logic              busy,
  input logic              armed,
  input logic              berr,
  input logic              hash_go,
  input logic [31:0]       hash_func,
  input logic [31:0]       hash_seed,
  input logic [RES_W-1:0]  hash_result,
  input logic [RES_W-1:0]  auth_q,
  input logic [NUM_SECRETS-1:0] lock_bits
);
  logic chal_w, stat_w;
  assign chal_w = wr_en && (addr == ADDR_W'(auth_pkg::REG_CHAL));
  assign stat_w = wr_en && (addr == ADDR_W'(auth_pkg::REG_STATUS));

  p_start_armed_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(armed) && $past(chal_w)));
  p_go_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    hash_go |-> (busy && !armed));
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (auth_q == $past(hash_result)));
  p_refuse_err_r4: assert property (@(posedge clk) disable iff (rst)
    (chal_w && !busy && !armed) |=> (berr && !busy));
  p_secrets_hold_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(hash_func) && $stable(hash_seed)));
  p_err_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(berr) |-> $past(stat_w && clr_bit));
  p_lock_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (($past(lock_bits) & ~lock_bits) == '0));
endmodule

bind auth_regs auth_regs_chk #(.ADDR_W(ADDR_W), .RES_W(RES_W), .NUM_SECRETS(NUM_SECRETS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .clr_bit(wdata[1]),
  .busy(busy), .armed(armed), .berr(berr), .hash_go(hash_go),
  .hash_func(hash_func), .hash_seed(hash_seed), .hash_result(hash_result),
  .auth_q(auth_q), .lock_bits(lock_bits)
);

// File: tb/auth_regs_tb.sv
module auth_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, NS = 4, BITC = 5;
  localparam logic [AW-1:0] A_ST = 0, A_SEL = 1, A_CH = 2, A_AU = 3, A_LOCK = 8;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, hash_func, hash_seed, hash_chal;
  logic hash_go;
  logic [7:0] hash_result;
  int total = 0, bad = 0;
  logic [31:0] sec [NS];
  logic [31:0] last_auth = 0, r;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] hmodel(input logic [31:0] f, s, c);
    logic [31:0] x;
    x = f ^ {s[23:0], s[31:24]} ^ (c + 32'h9e37_79b9);
    return x[7:0] ^ x[15:8] ^ x[23:16] ^ x[31:24] ^ f[31:24];
  endfunction

  assign hash_result = hmodel(hash_func, hash_seed, hash_chal);

  auth_regs #(.ADDR_W(AW), .RES_W(8), .NUM_SECRETS(NS), .BIT_CYCLES(BITC)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hash_go(hash_go), .hash_func(hash_func), .hash_seed(hash_seed),
    .hash_chal(hash_chal), .hash_result(hash_result));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic sel(input int fs, input int ss);
    wr(A_SEL, 32'((ss << 2) | fs));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] c;
    int fs, ss;
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    rd(A_ST, r);   chk("R1 status", r, 0);
    rd(A_SEL, r);  chk("R1 select", r, 0);
    rd(A_AU, r);   chk("R1 auth", r, 0);
    rd(A_LOCK, r); chk("R1 lock", r, 0);
    chk("R1 go", 32'(hash_go), 0);

    // program slots, R9 unlocked access
    for (int k = 0; k < NS; k++) begin
      sec[k] = $urandom;
      wr(AW'(9 + k), sec[k]);
      rd(AW'(9 + k), r); chk("R9 unlocked rd", r, sec[k]);
    end

    // random rounds
    for (int i = 0; i < 30; i++) begin
      fs = int'($urandom % NS); ss = int'($urandom % NS);
      c = $urandom;
      if ($urandom % 5 == 0) begin
        wr(A_CH, c);
        rd(A_ST, r); chk("R4 refused err", r, 2);
        rd(A_AU, r); chk("R4 auth kept", r, last_auth);
        wr(A_ST, 2);
        rd(A_ST, r); chk("R7 cleared", r, 0);
      end else begin
        sel(fs, ss);
        chk("R2 func", hash_func, sec[fs]);
        chk("R2 seed", hash_seed, sec[ss]);
        rd(A_ST, r); chk("R2 ready", r, 4);
        wr(A_CH, c);
        chk("R3 go", 32'(hash_go), 1);
        chk("R3 chal", hash_chal, c);
        rd(A_ST, r); chk("R3 busy", r, 1);
        repeat (BITC - 2) @(negedge clk);
        rd(A_AU, r); chk("R11 same-edge read old", r, last_auth);
        last_auth = 32'(hmodel(sec[fs], sec[ss], c));
        rd(A_AU, r); chk("R3 result", r, last_auth);
        rd(A_ST, r); chk("R3 idle", r, 0);
      end
    end

    // R5 challenge during busy
    sel(2, 1); c = $urandom;
    wr(A_CH, c);
    wr(A_CH, ~c);
    chk("R5 chal held", hash_chal, c);
    repeat (BITC) @(negedge clk);
    rd(A_ST, r); chk("R5 no err", r, 0);
    rd(A_AU, r); chk("R5 result", r, 32'(hmodel(sec[2], sec[1], c)));

    // R5 challenge on the final busy edge
    sel(3, 3); c = $urandom;
    wr(A_CH, c);
    repeat (BITC - 1) @(negedge clk);
    wr(A_CH, ~c);
    rd(A_ST, r); chk("R5 last-edge no err", r, 0);
    chk("R5 last-edge chal", hash_chal, c);

    // R6 select during busy
    sel(0, 0); c = $urandom;
    wr(A_CH, c);
    sel(3, 2);
    chk("R6 func held", hash_func, sec[0]);
    repeat (BITC) @(negedge clk);
    rd(A_ST, r);  chk("R6 not ready", r, 0);
    rd(A_SEL, r); chk("R6 select kept", r, 0);
    rd(A_AU, r);  chk("R6 result", r, 32'(hmodel(sec[0], sec[0], c)));

    // R7 sticky error
    wr(A_CH, 32'h1);
    wr(A_ST, 0); rd(A_ST, r); chk("R7 zero write", r, 2);
    wr(A_ST, 1); rd(A_ST, r); chk("R7 bit0 write", r, 2);
    wr(A_ST, 2); rd(A_ST, r); chk("R7 w1c", r, 0);

    // R8 lock word
    wr(A_LOCK, 1); rd(A_LOCK, r); chk("R8 set", r, 1);
    wr(A_LOCK, 4); rd(A_LOCK, r); chk("R8 or", r, 5);
    wr(A_LOCK, 0); rd(A_LOCK, r); chk("R8 no clear", r, 5);

    // R9 locked access
    rd(9, r);  chk("R9 locked rd", r, 0);
    rd(10, r); chk("R9 open rd", r, sec[1]);
    wr(9, 32'hdead_beef);
    rd(A_ST, r); chk("R9 blocked err", r, 2);
    wr(A_ST, 2);
    wr(11, 32'h1111_2222);
    rd(A_ST, r); chk("R9 blocked err2", r, 2);
    wr(A_ST, 2);

    // R10 engine path to locked slots, also proves writes were dropped
    sel(0, 2);
    chk("R10 func", hash_func, sec[0]);
    chk("R10 seed", hash_seed, sec[2]);
    c = $urandom;
    wr(A_CH, c);
    repeat (BITC) @(negedge clk);
    rd(A_AU, r); chk("R10 result", r, 32'(hmodel(sec[0], sec[2], c)));

    // R11 unmapped
    rd(5, r);  chk("R11 gap", r, 0);
    rd(13, r); chk("R11 beyond", r, 0);

    finish_run();
  end
endmodule